// File: doc/BRIEF.md
# Carry-Chained Arithmetic Logic Unit

This block is the purely combinational execute unit of a small processor core. It takes two 32-bit operands, a 4-bit operation code and the saved carry flag bit, and returns a 32-bit result with carry, zero and negative status bits in the same cycle. Operand muxing, register writeback and flag storage sit in the surrounding pipeline. This block only computes.

The operations fall into four groups. Addition and subtraction come in plain and carry-chained forms, so that values wider than one word can be handled. The bitwise group includes NOR. Shifts come in logical left, logical right and arithmetic right forms. The multiply group returns either word of the full 64-bit product, in signed or unsigned form. The one code left over, which is where division would sit, is reported as unsupported.

Top module: `chain_alu`

## Requirements
- R1: Code 0 gives `src_a + src_b` and code 1 gives `src_a + src_b + carry_in`. In both, `carry_out` is the carry out of bit 31.
- R2: Code 2 gives `src_a - src_b` and code 3 gives `src_a - src_b - carry_in`, modulo 2^32. In both, `carry_out` is 1 exactly when no borrow occurs: `src_a >= src_b` for code 2, and `src_a >= src_b + carry_in` as an unbounded integer for code 3.
- R3: Codes 4, 5, 6 and 7 give AND, OR, XOR and NOR of the two operands, bit by bit.
- R4: Codes 8, 9 and 10 shift `src_a` left logically, right logically, and right arithmetically (sign fill). The distance is `src_b[4:0]`. Bits 31..5 of `src_b` have no effect.
- R5: Codes 11 and 12 give the low and high words of the unsigned 64-bit product. Codes 13 and 14 give the low and high words of the signed (two's complement) product.
- R6: `zero` is 1 exactly when all 32 result bits are 0.
- R7: `negative` equals bit 31 of the result.
- R8: Code 15 forces the result to 0, sets `bad_op` to 1 and clears `carry_out`. `bad_op` is 0 for every other code.
- R9: For codes 4 through 14, `carry_out` is 0 and `carry_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand; its low 5 bits set the shift distance |
| carry_in | input | 1 | Saved carry flag, used by codes 1 and 3 |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry out, or NOT borrow for subtraction |
| zero | output | 1 | Result is all zeros |
| negative | output | 1 | Result bit 31 |
| bad_op | output | 1 | Unsupported operation code |

## Verification
The hardest case to reach is subtract-with-borrow where `src_b` is all ones and `carry_in` is 1. There the subtrahend overflows one word, so the result must equal `src_a` while `carry_out` stays 0. Random operands almost never produce this, so directed vectors aim at it. Directed vectors also cover the equal-operand borrow case, the signed square of the most negative value, and shift distances whose upper bits of `src_b` are set. Several thousand random vectors then cover all sixteen codes with `carry_in` toggled, and each one is compared against a behavioural model that uses 64-bit integer arithmetic.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD     = 4'd0,
        OP_ADDC    = 4'd1,
        OP_SUB     = 4'd2,
        OP_SUBB    = 4'd3,
        OP_AND     = 4'd4,
        OP_OR      = 4'd5,
        OP_XOR     = 4'd6,
        OP_NOR     = 4'd7,
        OP_SHL     = 4'd8,
        OP_SHR     = 4'd9,
        OP_SAR     = 4'd10,
        OP_MULU_LO = 4'd11,
        OP_MULU_HI = 4'd12,
        OP_MULS_LO = 4'd13,
        OP_MULS_HI = 4'd14,
        OP_RSVD    = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT,
        UNIT_MUL,
        UNIT_NONE
    } alu_unit_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_fn_e;

    typedef struct packed {
        alu_unit_e unit;
        logic      invert_b;
        logic      use_cin;
        logic_fn_e logic_fn;
        shift_fn_e shift_fn;
        logic      mul_signed;
        logic      mul_high;
        logic      illegal;
    } alu_ctrl_t;

    typedef struct packed {
        logic carry;
        logic zero;
        logic neg;
    } alu_flags_t;

    function automatic alu_ctrl_t decode_op(alu_op_e op);
        alu_ctrl_t c;
        c = '{unit: UNIT_NONE, invert_b: 1'b0, use_cin: 1'b0,
              logic_fn: LF_AND, shift_fn: SH_LEFT,
              mul_signed: 1'b0, mul_high: 1'b0, illegal: 1'b0};
        case (op)
            OP_ADD:     c.unit = UNIT_ARITH;
            OP_ADDC:    begin c.unit = UNIT_ARITH; c.use_cin = 1'b1; end
            OP_SUB:     begin c.unit = UNIT_ARITH; c.invert_b = 1'b1; end
            OP_SUBB:    begin c.unit = UNIT_ARITH; c.invert_b = 1'b1; c.use_cin = 1'b1; end
            OP_AND:     begin c.unit = UNIT_LOGIC; c.logic_fn = LF_AND; end
            OP_OR:      begin c.unit = UNIT_LOGIC; c.logic_fn = LF_OR;  end
            OP_XOR:     begin c.unit = UNIT_LOGIC; c.logic_fn = LF_XOR; end
            OP_NOR:     begin c.unit = UNIT_LOGIC; c.logic_fn = LF_NOR; end
            OP_SHL:     begin c.unit = UNIT_SHIFT; c.shift_fn = SH_LEFT;  end
            OP_SHR:     begin c.unit = UNIT_SHIFT; c.shift_fn = SH_RIGHT; end
            OP_SAR:     begin c.unit = UNIT_SHIFT; c.shift_fn = SH_ARITH; end
            OP_MULU_LO: c.unit = UNIT_MUL;
            OP_MULU_HI: begin c.unit = UNIT_MUL; c.mul_high = 1'b1; end
            OP_MULS_LO: begin c.unit = UNIT_MUL; c.mul_signed = 1'b1; end
            OP_MULS_HI: begin c.unit = UNIT_MUL; c.mul_signed = 1'b1; c.mul_high = 1'b1; end
            default:    c.illegal = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         invert_b,
    input  logic         cin_bit,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    assign b_eff = invert_b ? ~opb : opb;
    assign total = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin_bit};
    assign sum   = total[W-1:0];
    assign cout  = total[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import chain_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic_fn_e    fn,
    output logic [W-1:0] res
);
    always_comb begin
        case (fn)
            LF_AND:  res = opa & opb;
            LF_OR:   res = opa | opb;
            LF_XOR:  res = opa ^ opb;
            default: res = ~(opa | opb);
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import chain_alu_pkg::*;
#(
    parameter int unsigned W = 32,
    localparam int unsigned SH_W = $clog2(W)
) (
    input  logic [W-1:0]    val,
    input  logic [SH_W-1:0] amt,
    input  shift_fn_e       fn,
    output logic [W-1:0]    res
);
    logic          go_left;
    logic          fill;
    logic [W-1:0]  rev_in;
    logic [W-1:0]  src;
    logic [W-1:0]  stage [0:SH_W];
    logic [W-1:0]  rev_out;

    assign go_left = (fn == SH_LEFT);
    assign fill    = (fn == SH_ARITH) & val[W-1];

    // A left shift is a right shift on the bit-reversed word
    for (genvar j = 0; j < W; j++) begin : g_rev
        assign rev_in[j]  = val[W-1-j];
        assign rev_out[j] = stage[SH_W][W-1-j];
    end

    assign src      = go_left ? rev_in : val;
    assign stage[0] = src;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int unsigned D = 1 << i;
        assign stage[i+1] = amt[i] ? {{D{fill}}, stage[i][W-1:D]} : stage[i];
    end

    assign res = go_left ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
    parameter int unsigned W = 32,
    localparam int unsigned PW = 2 * W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         is_signed,
    input  logic         take_high,
    output logic [W-1:0] res
);
    logic          ext_a;
    logic          ext_b;
    logic [PW-1:0] wide_a;
    logic [PW-1:0] wide_b;
    logic [PW-1:0] prod;

    // Sign or zero extension to the product width; one array serves both forms
    assign ext_a  = is_signed & opa[W-1];
    assign ext_b  = is_signed & opb[W-1];
    assign wide_a = {{W{ext_a}}, opa};
    assign wide_b = {{W{ext_b}}, opb};
    assign prod   = wide_a * wide_b;
    assign res    = take_high ? prod[PW-1:W] : prod[W-1:0];
endmodule

// File: rtl/chain_alu.sv
module chain_alu
    import chain_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W,
    localparam int unsigned SH_W = $clog2(W)
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b,
    input  logic            carry_in,
    output logic [W-1:0]    result,
    output logic            carry_out,
    output logic            zero,
    output logic            negative,
    output logic            bad_op
);
    alu_ctrl_t  ctrl;
    alu_flags_t flags;
    logic [W-1:0] arith_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic [W-1:0] mul_res;
    logic         arith_cout;
    logic         cin_bit;

    assign ctrl    = decode_op(alu_op_e'(op_sel));
    // Subtraction adds NOT b plus one, less one more when a borrow comes in
    assign cin_bit = ctrl.use_cin ? (carry_in ^ ctrl.invert_b) : ctrl.invert_b;

    alu_addsub #(.W(W)) u_addsub (
        .opa      (src_a),
        .opb      (src_b),
        .invert_b (ctrl.invert_b),
        .cin_bit  (cin_bit),
        .sum      (arith_res),
        .cout     (arith_cout)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .opa (src_a),
        .opb (src_b),
        .fn  (ctrl.logic_fn),
        .res (logic_res)
    );

    alu_shifter #(.W(W)) u_shifter (
        .val (src_a),
        .amt (src_b[SH_W-1:0]),
        .fn  (ctrl.shift_fn),
        .res (shift_res)
    );

    alu_multiplier #(.W(W)) u_mult (
        .opa       (src_a),
        .opb       (src_b),
        .is_signed (ctrl.mul_signed),
        .take_high (ctrl.mul_high),
        .res       (mul_res)
    );

    always_comb begin
        case (ctrl.unit)
            UNIT_ARITH: result = arith_res;
            UNIT_LOGIC: result = logic_res;
            UNIT_SHIFT: result = shift_res;
            UNIT_MUL:   result = mul_res;
            default:    result = '0;
        endcase
    end

    assign flags.carry = (ctrl.unit == UNIT_ARITH) & arith_cout;
    assign flags.zero  = ~|result;
    assign flags.neg   = result[W-1];

    assign carry_out = flags.carry;
    assign zero      = flags.zero;
    assign negative  = flags.neg;
    assign bad_op    = ctrl.illegal;
endmodule

// File: rtl/chain_alu_checks.sv
module chain_alu_checks #(
    parameter int unsigned W = 32
) (
    input logic [3:0]   op_sel,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         zero,
    input logic         negative,
    input logic         bad_op
);
    logic [W:0]   wide_sum;
    logic [W-1:0] low_prod;

    assign wide_sum = {1'b0, src_a} + {1'b0, src_b};
    assign low_prod = src_a * src_b;

    always_comb begin
        if (!$isunknown({op_sel, src_a, src_b, carry_in})) begin
            p_add_sum_r1: assert (op_sel != 4'd0 || {carry_out, result} == wide_sum)
                else $error("add sum/carry mismatch");
            p_sub_notborrow_r2: assert (op_sel != 4'd2 || carry_out == (src_a >= src_b))
                else $error("subtract carry is not NOT-borrow");
            p_and_result_r3: assert (op_sel != 4'd4 || result == (src_a & src_b))
                else $error("AND result mismatch");
            p_lsr_msb_r4: assert (op_sel != 4'd9 || src_b[4:0] == 5'd0 || !negative)
                else $error("logical right shift left the sign bit set");
            p_mul_low_r5: assert (!(op_sel == 4'd11 || op_sel == 4'd13) || result == low_prod)
                else $error("low product word mismatch");
            p_equal_sub_zero_r6: assert (op_sel != 4'd2 || src_a != src_b || (zero && carry_out))
                else $error("equal-operand subtract not zero");
            p_sar_sign_r7: assert (op_sel != 4'd10 || !src_a[W-1] || negative)
                else $error("arithmetic shift lost the sign");
            p_bad_op_r8: assert (bad_op == (op_sel == 4'd15) &&
                                 (op_sel != 4'd15 || (result == '0 && !carry_out)))
                else $error("unsupported code handling wrong");
            p_carry_quiet_r9: assert (op_sel < 4'd4 || !carry_out)
                else $error("carry set outside arithmetic");
        end
    end
endmodule

bind chain_alu chain_alu_checks #(.W(W)) u_checks (
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero),
    .negative  (negative),
    .bad_op    (bad_op)
);

// File: tb/chain_alu_test.sv
module chain_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out, zero, negative, bad_op;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    chain_alu uut (
        .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .zero(zero),
        .negative(negative), .bad_op(bad_op)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%h b=%h cin=%0b: actual %h expected %h",
                     req, what, op_sel, src_a, src_b, carry_in, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic on 64-bit values
    task automatic apply(int op, logic [31:0] a, logic [31:0] b, bit cin);
        longint unsigned ua, ub, up;
        longint sa, sb, sp;
        logic [31:0] er;
        bit ec;
        string rq;
        @(negedge clk);
        op_sel = 4'(op); src_a = a; src_b = b; carry_in = cin;
        ua = {32'd0, a}; ub = {32'd0, b};
        sa = longint'($signed(a)); sb = longint'($signed(b));
        up = ua * ub; sp = sa * sb;
        ec = 0; er = 0;
        case (op)
            0:  begin er = 32'(ua + ub);        ec = ((ua + ub) >> 32) != 0; rq = "R1"; end
            1:  begin er = 32'(ua + ub + cin);  ec = ((ua + ub + cin) >> 32) != 0; rq = "R1"; end
            2:  begin er = a - b;               ec = (ua >= ub); rq = "R2"; end
            3:  begin er = a - b - 32'(cin);    ec = (ua >= ub + cin); rq = "R2"; end
            4:  begin er = a & b;    rq = "R3"; end
            5:  begin er = a | b;    rq = "R3"; end
            6:  begin er = a ^ b;    rq = "R3"; end
            7:  begin er = ~(a | b); rq = "R3"; end
            8:  begin er = a << b[4:0]; rq = "R4"; end
            9:  begin er = a >> b[4:0]; rq = "R4"; end
            10: begin er = 32'(sa >>> b[4:0]); rq = "R4"; end
            11: begin er = up[31:0];  rq = "R5"; end
            12: begin er = up[63:32]; rq = "R5"; end
            13: begin er = 32'(sp);       rq = "R5"; end
            14: begin er = 32'(sp >>> 32); rq = "R5"; end
            default: begin er = 0; rq = "R8"; end
        endcase
        @(posedge clk); #2;
        check(rq, "result", result, er);
        check((op < 4) ? rq : "R9", "carry_out", {31'd0, carry_out}, {31'd0, ec});
        check("R6", "zero", {31'd0, zero}, {31'd0, er == 0});
        check("R7", "negative", {31'd0, negative}, {31'd0, er[31]});
        check("R8", "bad_op", {31'd0, bad_op}, {31'd0, op == 15});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // reset state: all-zero inputs select add of zeros
        check("R6", "reset zero", {31'd0, zero}, 32'd1);
        check("R1", "reset result", result, 32'd0);
        rst = 1'b0;

        // R1 carry out of bit 31, with and without carry-in
        apply(0, 32'hFFFF_FFFF, 32'd1, 1);
        apply(1, 32'hFFFF_FFFF, 32'd0, 1);
        apply(1, 32'h7FFF_FFFF, 32'd0, 1);
        // R2 NOT-borrow including subtrahend wrap with borrow-in
        apply(2, 32'd5, 32'd5, 0);
        apply(2, 32'd3, 32'd5, 1);
        apply(3, 32'd7, 32'hFFFF_FFFF, 1);
        apply(3, 32'd5, 32'd5, 1);
        apply(3, 32'd5, 32'd5, 0);
        // R3 and R9: logic with carry-in set
        for (int op = 4; op < 8; op++) apply(op, 32'hF0F0_1234, 32'h0FF0_8421, 1);
        apply(7, 32'hFFFF_FFFF, 32'd0, 1);
        // R4 distances, ignored upper bits of src_b
        apply(8, 32'h8000_0001, 32'h0000_0024, 1);
        apply(9, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        apply(10, 32'h8000_0000, 32'd31, 0);
        apply(10, 32'h4000_0000, 32'd0, 1);
        // R5 product corners
        for (int op = 11; op < 15; op++) begin
            apply(op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
            apply(op, 32'h8000_0000, 32'h8000_0000, 0);
            apply(op, 32'h1234_5678, 32'hFEDC_BA98, 0);
        end
        // R8 unsupported code
        apply(15, 32'hDEAD_BEEF, 32'h1234_5678, 1);

        // random sweep over all codes, carry-in toggled
        for (int k = 0; k < 3000; k++)
            apply(k % 16, $urandom, $urandom, k[4]);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule